// File: doc/BRIEF.md
# Dual-Rate Occupancy Up/Down Counter

This block keeps track of how many entries sit in a two-port buffer whose writer and reader run on two related clocks. Write strobes arrive on a fast clock; read strobes arrive on a slow clock. The fast clock runs at exactly twice the slow clock, and every slow rising edge lines up with a fast rising edge. All occupancy state is held in the fast domain. A small phase tracker marks the second fast cycle of each slow cycle. Because of that mark, a read strobe held for one slow cycle is taken exactly once rather than twice.

The counter saturates at both ends and never wraps. A write that arrives while the buffer is full is refused, and it raises a one-fast-cycle write-error pulse. A read that arrives while the buffer is empty is refused, and it raises a one-fast-cycle read-error pulse. A busy flag shows a full buffer, and an available flag shows a non-empty one.

A three-state machine summarises the count:
- **EMPTY**: the count is zero.
- **PARTIAL**: the count is between zero and the maximum.
- **FULL**: the count is at its maximum of 2^CNT_W-1.

The machine moves between these states along four named transitions:
- **fill**: EMPTY to PARTIAL.
- **top**: PARTIAL to FULL.
- **drain**: PARTIAL to EMPTY.
- **release**: FULL to PARTIAL.

A synchronous clear, sampled on the fast clock, forces the machine to EMPTY from any state. CNT_W must be at least 2.

Top module: `dualrate_occ_counter`

## Requirements
- R1: While sclr is high across a slow rising edge, the count goes to zero. After that edge, busy, avail, wr_err and rd_err all read 0.
- R2: Each fast cycle with inc_req high adds one to the count, unless the count is already at maximum.
- R3: dec_req is driven from the slow clock. Each slow cycle in which it is high removes exactly one from the count, even when it is held high over many slow cycles. The decrement takes effect at the fast edge in the middle of that slow cycle.
- R4: busy is 1 exactly when the count equals 2^CNT_W-1.
- R5: avail is 1 exactly when the count is nonzero.
- R6: An increment that meets a full count leaves the count unchanged. wr_err is then 1 for exactly the one fast cycle after that edge.
- R7: A decrement that meets an empty count leaves the count unchanged. rd_err is then 1 for exactly the one fast cycle after that edge.
- R8: When the count is neither zero nor maximum, an increment and a decrement on the same fast edge leave the count unchanged.
- R9: At a full count, a coinciding increment and decrement lower the count by one and pulse wr_err.
- R10: At an empty count, a coinciding increment and decrement raise the count by one and pulse rd_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Slow clock, half the fast rate, rising edges aligned with the fast clock |
| clk_fast | input | 1 | Fast clock; all occupancy state lives here |
| sclr | input | 1 | Synchronous clear, active high |
| inc_req | input | 1 | Increment strobe, fast domain |
| dec_req | input | 1 | Decrement strobe, slow domain |
| busy | output | 1 | Count at maximum |
| avail | output | 1 | Count nonzero |
| wr_err | output | 1 | Pulse: increment refused at full |
| rd_err | output | 1 | Pulse: decrement refused at empty |

## Verification
The embedded properties check the following on every fast cycle:
- The slow-cycle mark alternates between fast cycles.
- A refused increment or decrement freezes the count and raises its error flag on the next cycle.
- A balanced increment and decrement in PARTIAL holds the count.

Only the bench scenarios can show that the flags follow the true occupancy over long sequences. This includes a read strobe held over several slow cycles draining one entry per slow cycle, continuous writes filling one entry per fast cycle, and the coincident requests at FULL and at EMPTY. Those scenarios also show that the clear brings everything back to zero from the middle of activity.

// File: rtl/occ_pkg.sv
package occ_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_t;
endpackage

// File: rtl/occ_phase_track.sv
// Marks the second fast cycle of each slow cycle, so that a slow-domain
// strobe is taken once per slow period.
module occ_phase_track (
    input  logic clk_slow,
    input  logic clk_fast,
    input  logic sclr,
    output logic slow_mark
);
    logic tog_slow;
    logic tog_fast;

    always_ff @(posedge clk_slow) begin
        if (sclr) tog_slow <= 1'b0;
        else      tog_slow <= ~tog_slow;
    end

    // Reset apart from tog_slow, so the first fast cycle after the clear
    // already carries the mark.
    always_ff @(posedge clk_fast) begin
        if (sclr) tog_fast <= 1'b1;
        else      tog_fast <= tog_slow;
    end

    assign slow_mark = tog_slow ^ tog_fast;

    // R3: the mark is present on alternate fast cycles only
    p_mark_alternates_r3: assert property (@(posedge clk_fast) disable iff (sclr)
        slow_mark |=> !slow_mark);
endmodule

// File: rtl/occ_core.sv
module occ_core
    import occ_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic clk_fast,
    input  logic sclr,
    input  logic up_req,
    input  logic dn_req,
    output logic busy,
    output logic avail,
    output logic wr_err,
    output logic rd_err
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    occ_state_t        state, state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic              wr_hit, rd_hit, up_ok, dn_ok;

    // refusal decisions and next count
    always_comb begin
        wr_hit = up_req && (state == ST_FULL);
        rd_hit = dn_req && (state == ST_EMPTY);
        up_ok  = up_req && !wr_hit;
        dn_ok  = dn_req && !rd_hit;
        unique case ({up_ok, dn_ok})
            2'b10:   cnt_n = cnt + CNT_ONE;
            2'b01:   cnt_n = cnt - CNT_ONE;
            default: cnt_n = cnt;
        endcase
    end

    // transitions: fill, top, drain, release
    always_comb begin
        state_n = state;
        unique case (state)
            ST_EMPTY:   if (cnt_n != '0) state_n = ST_PARTIAL;           // fill
            ST_PARTIAL: if (cnt_n == CNT_MAX) state_n = ST_FULL;         // top
                        else if (cnt_n == '0) state_n = ST_EMPTY;        // drain
            ST_FULL:    if (cnt_n != CNT_MAX) state_n = ST_PARTIAL;      // release
            default:    state_n = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk_fast) begin
        if (sclr) begin
            state  <= ST_EMPTY;
            cnt    <= '0;
            wr_err <= 1'b0;
            rd_err <= 1'b0;
        end else begin
            state  <= state_n;
            cnt    <= cnt_n;
            wr_err <= wr_hit;
            rd_err <= rd_hit;
        end
    end

    // level outputs from the state
    always_comb begin
        unique case (state)
            ST_EMPTY:   begin busy = 1'b0; avail = 1'b0; end
            ST_PARTIAL: begin busy = 1'b0; avail = 1'b1; end
            ST_FULL:    begin busy = 1'b1; avail = 1'b1; end
            default:    begin busy = 1'b0; avail = 1'b0; end
        endcase
    end

    p_no_overflow_r6: assert property (@(posedge clk_fast) disable iff (sclr)
        (state == ST_FULL && up_req && !dn_req) |=> ($stable(cnt) && wr_err));
    p_no_underflow_r7: assert property (@(posedge clk_fast) disable iff (sclr)
        (state == ST_EMPTY && dn_req && !up_req) |=> ($stable(cnt) && rd_err));
    p_balanced_hold_r8: assert property (@(posedge clk_fast) disable iff (sclr)
        (state == ST_PARTIAL && up_req && dn_req) |=> $stable(cnt));
    p_full_both_r9: assert property (@(posedge clk_fast) disable iff (sclr)
        (state == ST_FULL && up_req && dn_req) |=> (cnt == CNT_MAX - CNT_ONE && wr_err));
    p_empty_both_r10: assert property (@(posedge clk_fast) disable iff (sclr)
        (state == ST_EMPTY && up_req && dn_req) |=> (cnt == CNT_ONE && rd_err));
    p_busy_flag_r4: assert property (@(posedge clk_fast) disable iff (sclr)
        busy == (cnt == CNT_MAX));
endmodule

// File: rtl/dualrate_occ_counter.sv
module dualrate_occ_counter #(
    parameter int CNT_W = 8
) (
    input  logic clk_slow,
    input  logic clk_fast,
    input  logic sclr,
    input  logic inc_req,
    input  logic dec_req,
    output logic busy,
    output logic avail,
    output logic wr_err,
    output logic rd_err
);
    logic slow_mark;
    logic dec_take;

    initial begin
        if (CNT_W < 2) $error("CNT_W must be at least 2");
    end

    occ_phase_track u_phase (
        .clk_slow  (clk_slow),
        .clk_fast  (clk_fast),
        .sclr      (sclr),
        .slow_mark (slow_mark)
    );

    assign dec_take = dec_req && slow_mark;

    occ_core #(.CNT_W(CNT_W)) u_core (
        .clk_fast (clk_fast),
        .sclr     (sclr),
        .up_req   (inc_req),
        .dn_req   (dec_take),
        .busy     (busy),
        .avail    (avail),
        .wr_err   (wr_err),
        .rd_err   (rd_err)
    );
endmodule

// File: tb/tb_dualrate_occ_counter.sv
module tb_dualrate_occ_counter;
    localparam int FAST_PERIOD = 10;
    localparam int W   = 3;
    localparam int MAX = (1 << W) - 1;
    localparam int NV  = 16;
    // {inc first half, inc second half, dec, expected busy, expected avail}
    localparam logic [4:0] VEC [NV] = '{
        5'b11001, 5'b11001, 5'b11101, 5'b11011, 5'b10011, 5'b11111,
        5'b00101, 5'b00101, 5'b00101, 5'b00101, 5'b00101, 5'b00101,
        5'b00100, 5'b00100, 5'b10101, 5'b00100
    };

    logic clk_slow = 0, clk_fast = 0, sclr = 1, inc_req = 0, dec_req = 0;
    logic busy, avail, wr_err, rd_err;
    int total = 0, bad = 0, mcnt = 0;
    logic mwr = 0, mrd = 0;

    dualrate_occ_counter #(.CNT_W(W)) dut (
        .clk_slow(clk_slow), .clk_fast(clk_fast), .sclr(sclr),
        .inc_req(inc_req), .dec_req(dec_req),
        .busy(busy), .avail(avail), .wr_err(wr_err), .rd_err(rd_err));

    initial forever begin
        #(FAST_PERIOD/2) clk_fast = 1; clk_slow = 1;
        #(FAST_PERIOD/2) clk_fast = 0;
        #(FAST_PERIOD/2) clk_fast = 1; clk_slow = 0;
        #(FAST_PERIOD/2) clk_fast = 0;
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // model one fast edge
    task automatic model_edge(input logic inc, input logic dec);
        mwr = inc && (mcnt == MAX);
        mrd = dec && (mcnt == 0);
        mcnt = mcnt + ((inc && !mwr) ? 1 : 0) - ((dec && !mrd) ? 1 : 0);
    endtask

    task automatic check_all();
        chk(busy,   mcnt == MAX, "R4 busy");
        chk(avail,  mcnt != 0,   "R5 avail");
        chk(wr_err, mwr,         "R6 wr_err");
        chk(rd_err, mrd,         "R7 rd_err");
    endtask

    // one slow cycle; called just after a slow rising edge
    task automatic slow_step(input logic i0, input logic i1, input logic d);
        inc_req = i0; dec_req = d;
        @(posedge clk_fast); model_edge(i0, d); #2; check_all();
        inc_req = i1;
        @(posedge clk_fast); model_edge(i1, 1'b0); #2; check_all();
    endtask

    task automatic do_reset();
        sclr = 1; inc_req = 0; dec_req = 0;
        repeat (2) @(posedge clk_slow);
        #2 sclr = 0;
        mcnt = 0; mwr = 0; mrd = 0;
        chk(busy, 1'b0, "R1 busy after clear");
        chk(avail, 1'b0, "R1 avail after clear");
        chk(wr_err, 1'b0, "R1 wr_err after clear");
        chk(rd_err, 1'b0, "R1 rd_err after clear");
    endtask

    initial begin
        #(FAST_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // table walk: R2 fill, R3 held dec, R8 balance, R9 full+both, R10 empty+both
        for (int k = 0; k < NV; k++) begin
            slow_step(VEC[k][4], VEC[k][3], VEC[k][2]);
            chk(busy,  VEC[k][1], $sformatf("R2/R3 step %0d busy (R8 R9 R10)", k));
            chk(avail, VEC[k][0], $sformatf("R3 step %0d avail", k));
        end
        // R2: continuous increments saturate at MAX, wr_err pulse after overflow
        for (int k = 0; k < 5; k++) slow_step(1'b1, 1'b1, 1'b0);
        chk(busy, 1'b1, "R2 continuous fill reaches full");
        slow_step(1'b0, 1'b0, 1'b0);
        chk(wr_err, 1'b0, "R6 pulse lasts one cycle");
        // R3: dec held 7 slow cycles drains exactly to empty
        for (int k = 0; k < MAX - 1; k++) slow_step(1'b0, 1'b0, 1'b1);
        chk(avail, 1'b1, "R3 one entry left");
        slow_step(1'b0, 1'b0, 1'b1);
        chk(avail, 1'b0, "R3 drained");
        // R1: clear from mid occupancy
        slow_step(1'b1, 1'b1, 1'b0);
        do_reset();
        slow_step(1'b0, 1'b0, 1'b1);
        chk(rd_err, 1'b0, "R7 pulse over after one cycle");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule